// File: doc/BRIEF.md
# Multi-drop UART command address filter

This block sits behind a UART byte receiver in a slave device. Up to eight identical slaves share one serial bus. A frame starts with a sync byte. The byte after it is the command byte. That byte holds a 3-bit slave address in its three least significant bits and a 5-bit command code in its upper five bits. The filter compares the embedded address with the slave's own configured address. On a match it passes the command byte and the rest of the frame to the command executor. On a mismatch it silently drops the whole frame. Command codes on a small parameterised broadcast list are accepted whatever address they carry.

A configuration bit also selects where the serial bit engine connects. When the bit is clear, only the dedicated receive and transmit pins are used. When it is set, the same engine also drives an open-drain one-wire line, which it can only pull low, and listens to that line. The dedicated pins keep working. While the engine is transmitting, the one-wire receive input is masked so the slave does not decode its own echo.

Top module: `mdrop_addr_filter`

## Requirements
- R1: During and after synchronous reset, `fwd_valid` and `fwd_cmd` are 0 and the parser is hunting for a sync byte.
- R2: While hunting, every received byte other than 0x55 is ignored and produces no output. A 0x55 byte is never forwarded while hunting; it arms the parser so that the next byte is taken as the command byte.
- R3: A command byte whose bits [2:0] equal `cfg_addr` is forwarded one clock after it arrives, with `fwd_valid`=1, `fwd_cmd`=1 and `fwd_data` equal to the byte.
- R4: After an accepted command byte, each further byte of the frame is forwarded one clock later with `fwd_cmd`=0 and unchanged data, including data bytes of value 0x55.
- R5: If a command byte's bits [2:0] differ from `cfg_addr` and its code is not a broadcast code, that byte and every following byte up to the end of the frame produce no output.
- R6: A command byte whose bits [7:3] equal one of the broadcast codes (default list 3, 12, 17, 30) is accepted and forwarded like R3, whatever its address bits are.
- R7: A pulse on `rx_frame_end` clears the accept state and returns the parser to hunting. A byte presented in the same cycle as the pulse is dropped, and the output in the following cycle is idle.
- R8: With `cfg_wire_sel`=0, `ow_pull` is 0, `eng_rx_bit` follows `pin_rxd`, and `pin_txd` follows `eng_tx_bit`.
- R9: With `cfg_wire_sel`=1, `ow_pull` equals the inverse of `eng_tx_bit` and `pin_txd` still follows `eng_tx_bit`. While `eng_tx_busy`=0, `eng_rx_bit` is the AND of `pin_rxd` and `ow_in`, where both lines idle high.
- R10: With `cfg_wire_sel`=1 and `eng_tx_busy`=1, `ow_in` is masked and `eng_rx_bit` follows `pin_rxd` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 3 | Own slave address, loaded from nonvolatile configuration |
| cfg_wire_sel | input | 1 | 1 = also route the bit engine to the one-wire line |
| rx_valid | input | 1 | Received byte strobe from the UART receiver |
| rx_byte | input | 8 | Received byte |
| rx_frame_end | input | 1 | End-of-frame pulse from the receiver |
| fwd_valid | output | 1 | Forwarded byte strobe to the command executor |
| fwd_cmd | output | 1 | Forwarded byte is the command byte |
| fwd_data | output | 8 | Forwarded byte |
| pin_rxd | input | 1 | Dedicated receive pin |
| pin_txd | output | 1 | Dedicated transmit pin |
| ow_in | input | 1 | Sensed level of the one-wire line |
| ow_pull | output | 1 | 1 = pull the one-wire line low |
| eng_rx_bit | output | 1 | Serial input to the UART bit engine |
| eng_tx_bit | input | 1 | Serial output from the UART bit engine |
| eng_tx_busy | input | 1 | Bit engine is transmitting |

## Verification
The hardest case to reach from the ports is a sync or command pattern arriving in the wrong parser state: a 0x55 inside the data of an accepted frame, a broadcast code carrying a foreign address, and a frame-end pulse that lands on the same clock as a byte. Directed frames set up each of these. A long random stream then follows, biased towards sync bytes, short frames, frequent frame-end pulses and address changes between frames. A behavioural model tracks the frame state and compares the forwarded stream and the pin routing on every clock.

// File: rtl/mdf_pkg.sv
package mdf_pkg;
    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;
    localparam int CODE_W = BYTE_W - ADDR_W;
    localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'h55;

    typedef enum logic [1:0] {
        PS_HUNT = 2'd0,
        PS_CMD  = 2'd1,
        PS_BODY = 2'd2
    } parse_t;

    typedef struct packed {
        logic              valid;
        logic              is_cmd;
        logic [BYTE_W-1:0] data;
    } fwd_t;

    function automatic logic [ADDR_W-1:0] cmd_addr(input logic [BYTE_W-1:0] b);
        return b[ADDR_W-1:0];
    endfunction

    function automatic logic [CODE_W-1:0] cmd_code(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1:ADDR_W];
    endfunction
endpackage

// File: rtl/mdf_bcast_match.sv
module mdf_bcast_match
    import mdf_pkg::*;
#(
    parameter int                         NUM  = 4,
    parameter logic [NUM*CODE_W-1:0]      LIST = {5'd30, 5'd17, 5'd12, 5'd3}
) (
    input  logic [CODE_W-1:0] code,
    output logic              hit
);
    logic [NUM-1:0] hits;

    for (genvar i = 0; i < NUM; i++) begin : g_cmp
        assign hits[i] = (code == LIST[i*CODE_W +: CODE_W]);
    end

    assign hit = |hits;
endmodule

// File: rtl/mdf_frame_gate.sv
module mdf_frame_gate
    import mdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_frame_end,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              bc_hit,
    output fwd_t              fwd
);
    parse_t state_q;
    logic   accept_q;
    logic   addr_hit;
    logic   take_cmd;

    assign addr_hit = (cmd_addr(rx_byte) == own_addr);
    assign take_cmd = addr_hit || bc_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PS_HUNT;
            accept_q <= 1'b0;
            fwd      <= '0;
        end else begin
            fwd.valid  <= 1'b0;
            fwd.is_cmd <= 1'b0;
            if (rx_frame_end) begin
                state_q  <= PS_HUNT;
                accept_q <= 1'b0;
            end else if (rx_valid) begin
                unique case (state_q)
                    PS_HUNT: begin
                        if (rx_byte == SYNC_BYTE) state_q <= PS_CMD;
                    end
                    PS_CMD: begin
                        state_q  <= PS_BODY;
                        accept_q <= take_cmd;
                        if (take_cmd) begin
                            fwd.valid  <= 1'b1;
                            fwd.is_cmd <= 1'b1;
                            fwd.data   <= rx_byte;
                        end
                    end
                    PS_BODY: begin
                        if (accept_q) begin
                            fwd.valid <= 1'b1;
                            fwd.data  <= rx_byte;
                        end
                    end
                    default: state_q <= PS_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdf_pin_route.sv
module mdf_pin_route (
    input  logic wire_sel,
    input  logic pin_rxd,
    input  logic ow_in,
    input  logic tx_bit,
    input  logic tx_busy,
    output logic pin_txd,
    output logic ow_pull,
    output logic uart_rx
);
    logic ow_seen;

    assign ow_seen = (wire_sel && !tx_busy) ? ow_in : 1'b1;
    assign uart_rx = pin_rxd & ow_seen;
    assign pin_txd = tx_bit;
    assign ow_pull = wire_sel & ~tx_bit;
endmodule

// File: rtl/mdrop_addr_filter.sv
module mdrop_addr_filter
    import mdf_pkg::*;
#(
    parameter int                         BCAST_NUM  = 4,
    parameter logic [BCAST_NUM*CODE_W-1:0] BCAST_LIST = {5'd30, 5'd17, 5'd12, 5'd3}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wire_sel,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_frame_end,
    output logic              fwd_valid,
    output logic              fwd_cmd,
    output logic [BYTE_W-1:0] fwd_data,
    input  logic              pin_rxd,
    output logic              pin_txd,
    input  logic              ow_in,
    output logic              ow_pull,
    output logic              eng_rx_bit,
    input  logic              eng_tx_bit,
    input  logic              eng_tx_busy
);
    logic bc_hit;
    fwd_t fwd;

    mdf_bcast_match #(.NUM(BCAST_NUM), .LIST(BCAST_LIST)) i_bcast (
        .code (cmd_code(rx_byte)),
        .hit  (bc_hit)
    );

    mdf_frame_gate i_gate (
        .clk          (clk),
        .rst          (rst),
        .rx_valid     (rx_valid),
        .rx_byte      (rx_byte),
        .rx_frame_end (rx_frame_end),
        .own_addr     (cfg_addr),
        .bc_hit       (bc_hit),
        .fwd          (fwd)
    );

    mdf_pin_route i_route (
        .wire_sel (cfg_wire_sel),
        .pin_rxd  (pin_rxd),
        .ow_in    (ow_in),
        .tx_bit   (eng_tx_bit),
        .tx_busy  (eng_tx_busy),
        .pin_txd  (pin_txd),
        .ow_pull  (ow_pull),
        .uart_rx  (eng_rx_bit)
    );

    assign fwd_valid = fwd.valid;
    assign fwd_cmd   = fwd.is_cmd;
    assign fwd_data  = fwd.data;
endmodule

// File: rtl/mdf_chk.sv
module mdf_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_wire_sel,
    input logic       rx_valid,
    input logic [7:0] rx_byte,
    input logic       rx_frame_end,
    input logic       fwd_valid,
    input logic       fwd_cmd,
    input logic [7:0] fwd_data,
    input logic       pin_rxd,
    input logic       ow_pull,
    input logic       eng_rx_bit,
    input logic       eng_tx_busy
);
    // R2
    no_output_without_byte_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> $past(rx_valid));

    // R4
    data_passes_unchanged_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (fwd_data == $past(rx_byte)));

    // R3
    cmd_flag_only_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
        fwd_cmd |-> fwd_valid);

    // R7
    frame_end_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        rx_frame_end |=> !fwd_valid);

    // R8
    no_pull_when_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_wire_sel |-> !ow_pull);

    // R10
    echo_masked_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_wire_sel && eng_tx_busy) |-> (eng_rx_bit == pin_rxd));
endmodule

bind mdrop_addr_filter mdf_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_wire_sel (cfg_wire_sel),
    .rx_valid     (rx_valid),
    .rx_byte      (rx_byte),
    .rx_frame_end (rx_frame_end),
    .fwd_valid    (fwd_valid),
    .fwd_cmd      (fwd_cmd),
    .fwd_data     (fwd_data),
    .pin_rxd      (pin_rxd),
    .ow_pull      (ow_pull),
    .eng_rx_bit   (eng_rx_bit),
    .eng_tx_busy  (eng_tx_busy)
);

// File: tb/test_mdrop_addr_filter.sv
module test_mdrop_addr_filter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cfg_addr = 3'd5;
    logic       cfg_wire_sel = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_frame_end = 1'b0;
    logic       fwd_valid, fwd_cmd, pin_txd, ow_pull, eng_rx_bit;
    logic [7:0] fwd_data;
    logic       pin_rxd = 1'b1;
    logic       ow_in = 1'b1;
    logic       eng_tx_bit = 1'b1;
    logic       eng_tx_busy = 1'b0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mdrop_addr_filter #(
        .BCAST_NUM  (4),
        .BCAST_LIST ({5'd30, 5'd17, 5'd12, 5'd3})
    ) i_mdrop_addr_filter (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wire_sel(cfg_wire_sel),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_frame_end(rx_frame_end),
        .fwd_valid(fwd_valid), .fwd_cmd(fwd_cmd), .fwd_data(fwd_data),
        .pin_rxd(pin_rxd), .pin_txd(pin_txd), .ow_in(ow_in), .ow_pull(ow_pull),
        .eng_rx_bit(eng_rx_bit), .eng_tx_bit(eng_tx_bit), .eng_tx_busy(eng_tx_busy)
    );

    // behavioural reference
    int         m_phase = 0;   // 0 waiting for sync, 1 expecting command, 2 in frame
    bit         m_take = 1'b0;
    bit         exp_v = 1'b0;
    bit         exp_c = 1'b0;
    logic [7:0] exp_d = 8'h00;
    string      exp_tag = "R1";
    bit         started = 1'b0;
    int         bcast_codes[4] = '{3, 12, 17, 30};

    function automatic bit in_bcast(input int code);
        foreach (bcast_codes[k]) if (bcast_codes[k] == code) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        bit mine, bc;
        started = 1'b1;
        exp_v = 1'b0;
        exp_c = 1'b0;
        if (rst) begin
            m_phase = 0; m_take = 1'b0; exp_tag = "R1";
        end else if (rx_frame_end) begin
            m_phase = 0; m_take = 1'b0; exp_tag = "R7";
        end else if (rx_valid) begin
            if (m_phase == 0) begin
                exp_tag = "R2";
                if (rx_byte == 8'h55) m_phase = 1;
            end else if (m_phase == 1) begin
                mine = (int'(rx_byte & 8'h07) == int'(cfg_addr));
                bc = in_bcast(int'(rx_byte >> 3));
                m_take = mine || bc;
                exp_tag = mine ? "R3" : (bc ? "R6" : "R5");
                if (m_take) begin exp_v = 1'b1; exp_c = 1'b1; exp_d = rx_byte; end
                m_phase = 2;
            end else begin
                exp_tag = m_take ? "R4" : "R5";
                if (m_take) begin exp_v = 1'b1; exp_d = rx_byte; end
            end
        end else begin
            exp_tag = (m_phase == 2 && !m_take) ? "R5" : "R2";
        end
    end

    always @(negedge clk) begin
        bit e_rx, e_pull;
        string rt;
        if (started && !done) begin
            checks++;
            if (fwd_valid !== exp_v || fwd_cmd !== exp_c || (exp_v && fwd_data !== exp_d)) begin
                failures++;
                $display("FAIL %s: fwd v/c/d = %b/%b/%h expected %b/%b/%h",
                         exp_tag, fwd_valid, fwd_cmd, fwd_data, exp_v, exp_c, exp_d);
            end
            e_rx   = cfg_wire_sel ? (pin_rxd & (eng_tx_busy | ow_in)) : pin_rxd;
            e_pull = cfg_wire_sel & ~eng_tx_bit;
            rt = !cfg_wire_sel ? "R8" : (eng_tx_busy ? "R10" : "R9");
            checks++;
            if (eng_rx_bit !== e_rx || ow_pull !== e_pull || pin_txd !== eng_tx_bit) begin
                failures++;
                $display("FAIL %s: rx/pull/txd = %b/%b/%b expected %b/%b/%b",
                         rt, eng_rx_bit, ow_pull, pin_txd, e_rx, e_pull, eng_tx_bit);
            end
        end
    end

    task automatic step(input bit v, input logic [7:0] b, input bit fe);
        @(negedge clk);
        #1;
        rx_valid = v; rx_byte = b; rx_frame_end = fe;
    endtask

    task automatic frame(input logic [7:0] cmd, input int n, input logic [7:0] seed);
        step(1, 8'h55, 0);
        step(1, cmd, 0);
        for (int i = 0; i < n; i++) step(1, seed + 8'(i * 37), 0);
        step(0, 8'h00, 1);
        step(0, 8'h00, 0);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;                              // R1 checked during reset
        step(1, 8'h2D, 0); step(1, 8'h05, 0);       // R2 junk before sync
        frame({5'd9, 3'd5}, 3, 8'h10);              // R3 own address
        step(1, 8'h55, 0); step(1, {5'd9, 3'd5}, 0);// R4 0x55 inside data
        step(1, 8'h55, 0); step(1, 8'h55, 0); step(0, 0, 1); step(0, 0, 0);
        frame({5'd9, 3'd2}, 4, 8'h20);              // R5 foreign address dropped
        frame({5'd17, 3'd2}, 2, 8'h30);             // R6 broadcast foreign address
        frame({5'd30, 3'd5}, 1, 8'h40);             // R6 broadcast own address
        step(1, 8'h55, 0); step(1, {5'd1, 3'd5}, 0);// R7 byte with frame end dropped
        step(1, 8'hA1, 1); step(1, 8'hA2, 0); step(0, 0, 0);
        cfg_addr = 3'd2;
        frame({5'd9, 3'd2}, 2, 8'h50);              // R3 new address
        for (int k = 0; k < 32; k++) begin          // R8 R9 R10 sweep
            @(negedge clk); #1;
            {cfg_wire_sel, eng_tx_busy, eng_tx_bit, pin_rxd, ow_in} = 5'(k);
        end
        for (int n = 0; n < 3000; n++) begin        // random traffic
            int r;
            @(negedge clk); #1;
            r = $urandom_range(0, 99);
            rx_valid = (r < 70);
            rx_byte = (r < 20) ? 8'h55 : 8'($urandom_range(0, 255));
            rx_frame_end = (r > 90);
            if (r == 50) cfg_addr = 3'($urandom_range(0, 7));
            {cfg_wire_sel, eng_tx_busy, eng_tx_bit, pin_rxd, ow_in} = 5'($urandom_range(0, 31));
        end
        step(0, 8'h00, 1);
        repeat (2) @(negedge clk);
        #2 done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule